// File: doc/BRIEF.md
# Bipolar Line Code Encoder

This block turns a serial NRZ transmit stream into two rail outputs, one for positive pulses and one for negative pulses, and it handles one bit per transmit clock. Coding can be switched off, so the data passes straight through on the positive rail. With coding on, the block applies plain alternate mark inversion, or alternate mark inversion with zero-run substitution. The substitution uses either the eight-zero scheme (B8ZS) or the four-zero scheme (HDB3).

The block holds each bit in an eight-stage look-ahead window. A zero run that has fully arrived in the window is rewritten before any of it leaves. Every data bit therefore takes the same number of cycles to reach the outputs in every mode. An alarm input overrides the data and sends continuous alternating pulses, which is the all-ones alarm signal. A synchronous power-down input clears the window, the output registers and all polarity history.

The configuration inputs are static while the block is in service.

Top module: `bipolar_line_encoder`

## Requirements
- R1: A data bit sampled at clock edge k reaches `pos_out`/`neg_out` at edge k+8, in every mode except while alarm insertion is active.
- R2: With `code_en`=0 and `alarm_ins`=0, `pos_out` equals the delayed data bit and `neg_out` stays 0.
- R3: With `code_en`=1 and `ami_sel`=1, a 0 bit gives no pulse and each 1 bit gives a pulse of opposite polarity to the previous pulse. The first pulse after power-down is positive (`pos_out`).
- R4: With `code_en`=1, `ami_sel`=0 and `hdb3_sel`=0, every run of eight zeros, counted from the previous mark or substitution, is sent as 0,0,0,V,B,0,V,B in time order. V has the same polarity as the pulse before it. B has the opposite polarity to the pulse before it.
- R5: With `code_en`=1, `ami_sel`=0 and `hdb3_sel`=1, every run of four zeros is sent as 0,0,0,V when an odd number of pulses went out since the last V. Otherwise it is sent as B,0,0,V. The count is zero (even) after power-down, and B counts as a pulse.
- R6: While `alarm_ins`=1, every bit period carries a pulse one edge after the alarm is sampled. The pulses alternate in polarity and continue from the last pulse sent. This overrides all other modes.
- R7: `pos_out` and `neg_out` are never both 1.
- R8: `pwr_dn` is a synchronous reset. At the edge after it is sampled, both outputs are 0 and the polarity and parity history is cleared. Bits sampled before power-down never join a zero run after it, so no pulse appears until new data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| pwr_dn | input | 1 | Synchronous power-down reset, active high |
| code_en | input | 1 | 1 = coding active, 0 = transparent |
| ami_sel | input | 1 | 1 = plain AMI, 0 = zero-substitution coding |
| hdb3_sel | input | 1 | With substitution: 1 = HDB3, 0 = B8ZS |
| alarm_ins | input | 1 | Alarm insertion: continuous AMI ones |
| nrz_in | input | 1 | Serial NRZ data input |
| pos_out | output | 1 | Positive pulse rail |
| neg_out | output | 1 | Negative pulse rail |

## Verification
The bench builds the block at its only configuration: an eight-stage window, with eight-zero and four-zero run lengths. It replays two streams in every line-code mode. The first stream is built from zero runs of every length from 0 to 12, each preceded by one or two marks, so both HDB3 parities and runs that straddle the window boundary come up. The second stream is a sparse pseudo-random sequence. Expected pulses come from a greedy left-to-right substitution and polarity model in the bench. Each stream begins with a power-down, so the first-pulse polarity and the isolation of old window contents are checked each time.

// File: rtl/bipolar_line_encoder.sv
`timescale 1ns/1ps
module bipolar_line_encoder (
  input  logic clk,
  input  logic pwr_dn,
  input  logic code_en,
  input  logic ami_sel,
  input  logic hdb3_sel,
  input  logic alarm_ins,
  input  logic nrz_in,
  output logic pos_out,
  output logic neg_out
);
  localparam int DEPTH   = 8;
  localparam int HDB_RUN = 4;
  localparam logic [1:0] S_ZERO = 2'd0, S_ONE = 2'd1, S_BIP = 2'd2, S_VIOL = 2'd3;

  logic [1:0]       sym_q [DEPTH];
  logic [1:0]       sym_d [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic             last_pol_q, last_pol_d, odd_q, odd_d, pos_d, neg_d;
  logic             z_full, z_half, odd_ahead;
  logic [1:0]       out_sym;
  wire              subst_on = code_en & ~ami_sel;

  function automatic logic par_step(input logic p, input logic v, input logic [1:0] s);
    if (!v || s == S_ZERO) return p;
    if (s == S_VIOL) return 1'b0;
    return ~p;
  endfunction

  always_comb begin
    vld_d    = {vld_q[DEPTH-2:0], 1'b1};
    sym_d[0] = nrz_in ? S_ONE : S_ZERO;
    for (int i = 1; i < DEPTH; i++) sym_d[i] = sym_q[i-1];
    z_full = &vld_d;
    z_half = &vld_d[HDB_RUN-1:0];
    for (int i = 0; i < DEPTH; i++) begin
      if (sym_d[i] != S_ZERO) begin
        z_full = 1'b0;
        if (i < HDB_RUN) z_half = 1'b0;
      end
    end
    odd_d     = par_step(odd_q, vld_q[DEPTH-1], sym_q[DEPTH-1]);
    odd_ahead = odd_d;
    for (int i = DEPTH-1; i >= HDB_RUN; i--) odd_ahead = par_step(odd_ahead, vld_d[i], sym_d[i]);
    if (subst_on && !hdb3_sel && z_full) begin
      sym_d[4] = S_VIOL;
      sym_d[3] = S_BIP;
      sym_d[1] = S_VIOL;
      sym_d[0] = S_BIP;
    end
    if (subst_on && hdb3_sel && z_half) begin
      sym_d[0] = S_VIOL;
      if (!odd_ahead) sym_d[HDB_RUN-1] = S_BIP;
    end
  end

  assign out_sym = alarm_ins ? S_ONE : (vld_q[DEPTH-1] ? sym_q[DEPTH-1] : S_ZERO);

  always_comb begin
    last_pol_d = last_pol_q;
    pos_d      = 1'b0;
    neg_d      = 1'b0;
    if (!code_en && !alarm_ins) begin
      pos_d = (out_sym == S_ONE);
    end else if (out_sym != S_ZERO) begin
      last_pol_d = (out_sym == S_VIOL) ? last_pol_q : ~last_pol_q;
      pos_d      = last_pol_d;
      neg_d      = ~last_pol_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pwr_dn) begin
      for (int i = 0; i < DEPTH; i++) sym_q[i] <= S_ZERO;
      vld_q      <= '0;
      last_pol_q <= 1'b0;
      odd_q      <= 1'b0;
      pos_out    <= 1'b0;
      neg_out    <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) sym_q[i] <= sym_d[i];
      vld_q      <= vld_d;
      last_pol_q <= last_pol_d;
      odd_q      <= odd_d;
      pos_out    <= pos_d;
      neg_out    <= neg_d;
    end
  end

  a_r7_exclusive: assert property (@(posedge clk) disable iff (pwr_dn) !(pos_out && neg_out));
  a_r6_alarm_pulse: assert property (@(posedge clk) disable iff (pwr_dn) alarm_ins |=> (pos_out ^ neg_out));
  a_r2_no_neg: assert property (@(posedge clk) disable iff (pwr_dn) (!code_en && !alarm_ins) |=> !neg_out);
  a_r8_quiet: assert property (@(posedge clk) pwr_dn |=> (!pos_out && !neg_out));
endmodule

// File: tb/bipolar_line_encoder_tb_top.sv
`timescale 1ns/1ps
module bipolar_line_encoder_tb_top;
  logic clk = 1'b0;
  logic pwr_dn = 1'b1, code_en = 1'b0, ami_sel = 1'b0, hdb3_sel = 1'b0, alarm_ins = 1'b0, nrz_in = 1'b0;
  logic pos_out, neg_out;
  int   n_checks = 0, n_fail = 0;
  bit   din [256];
  bit   ep [256];
  bit   en [256];
  int   len;

  always #4 clk = ~clk;

  bipolar_line_encoder dut_i (
    .clk(clk), .pwr_dn(pwr_dn), .code_en(code_en), .ami_sel(ami_sel), .hdb3_sel(hdb3_sel),
    .alarm_ins(alarm_ins), .nrz_in(nrz_in), .pos_out(pos_out), .neg_out(neg_out));

  task automatic check(input string tag, input int idx, input bit xp, input bit xn);
    n_checks++;
    if (pos_out !== xp || neg_out !== xn) begin
      n_fail++;
      $display("FAIL %s bit %0d: got pos=%0b neg=%0b exp pos=%0b neg=%0b", tag, idx, pos_out, neg_out, xp, xn);
    end
  endtask

  // mode: 0 transparent, 1 AMI, 2 B8ZS, 3 HDB3
  task automatic encode(input int mode, input int total);
    int sym [256];
    int zr = 0;
    bit par = 0, last = 0, pol;
    for (int i = 0; i < total; i++) begin
      if (din[i]) begin sym[i] = 1; zr = 0; par = ~par; end
      else begin sym[i] = 0; zr++; end
      if (mode == 2 && zr == 8) begin
        sym[i-4] = 3; sym[i-3] = 2; sym[i-1] = 3; sym[i] = 2; zr = 0;
      end
      if (mode == 3 && zr == 4) begin
        sym[i] = 3;
        if (!par) sym[i-3] = 2;
        par = 0; zr = 0;
      end
    end
    for (int i = 0; i < total; i++) begin
      if (mode == 0) begin ep[i] = din[i]; en[i] = 0; end
      else if (sym[i] == 0) begin ep[i] = 0; en[i] = 0; end
      else begin
        pol = (sym[i] == 3) ? last : ~last;
        last = pol; ep[i] = pol; en[i] = ~pol;
      end
    end
  endtask

  task automatic power_down(input string tag);
    @(negedge clk); pwr_dn = 1'b1; nrz_in = 1'b0; alarm_ins = 1'b0;
    @(negedge clk);
    @(negedge clk); check(tag, -1, 1'b0, 1'b0);
  endtask

  task automatic run_stream(input int mode);
    string tag;
    int total = len + 10;
    case (mode)
      0: tag = "R1 R2 transparent";
      1: tag = "R1 R3 AMI";
      2: tag = "R1 R4 B8ZS";
      default: tag = "R1 R5 HDB3";
    endcase
    for (int i = len; i < total; i++) din[i] = 0;
    encode(mode, total);
    power_down("R8 reset");
    code_en = (mode != 0); ami_sel = (mode == 1); hdb3_sel = (mode == 3);
    for (int n = 0; n < len + 9; n++) begin
      if (n > 0) @(negedge clk);
      pwr_dn = 1'b0;
      if (n >= 9) check(tag, n - 9, ep[n-9], en[n-9]);
      else if (n >= 1) check("R8 flushed", n, 1'b0, 1'b0);
      nrz_in = din[n];
    end
  endtask

  task automatic build_runs();
    len = 0;
    for (int k = 0; k < 9; k++) din[len++] = 0;
    for (int z = 0; z <= 12; z++) begin
      din[len++] = 1;
      if (z % 2 == 0) din[len++] = 1;
      for (int k = 0; k < z; k++) din[len++] = 0;
    end
    din[len++] = 1;
  endtask

  task automatic build_lfsr();
    logic [15:0] r = 16'hACE1;
    len = 120;
    for (int i = 0; i < len; i++) begin
      din[i] = r[0] & r[3];
      r = {r[0] ^ r[2] ^ r[3] ^ r[5], r[15:1]};
    end
  endtask

  task automatic run_alarm(input bit en_code);
    power_down("R8 reset");
    code_en = en_code; ami_sel = 1'b0; hdb3_sel = 1'b1;
    for (int n = 0; n < 17; n++) begin
      if (n > 0) @(negedge clk);
      pwr_dn = 1'b0; alarm_ins = 1'b1; nrz_in = n[0];
      if (n >= 1) check("R6 alarm", n - 1, ((n - 1) % 2) == 0, ((n - 1) % 2) == 1);
    end
    alarm_ins = 1'b0;
  endtask

  initial begin
    build_runs();
    for (int m = 0; m < 4; m++) run_stream(m);
    build_lfsr();
    for (int m = 0; m < 4; m++) run_stream(m);
    run_alarm(1'b1);
    run_alarm(1'b0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule